// File: doc/BRIEF.md
# Time-Stamped Column Sweep Controller

This block drives the readout sweep of a sensor matrix made of macro-pixels. The matrix has `NCOL` macro-pixel columns of `NROW` rows. Each macro-pixel is two pixel columns wide. Macro-pixel number `c*NROW + r` sits in column `c`, row `r`.

A slow time-window clock sets the time resolution. At each rising edge of that clock, every enabled macro-pixel whose fast-OR is high is frozen by dropping its latch enable. The map of those macro-pixels is then queued in a small scan buffer together with the current time stamp. A sweeper pops the maps one at a time and announces each with a start-of-scan strobe that carries the stamp. It then walks only the columns that hold a selected macro-pixel, one pixel column per clock, and raises the row out-enables of the selected rows. After the second pixel column of a macro-pixel column has been driven, the frozen macro-pixels of that column are released.

When the buffer is full, fired macro-pixels are left running and the lost-window counter advances. A later window then stores the merged map, so hits lose time resolution but are never dropped. After reset, a clean-up pass walks all pixel columns with every row enabled.

Top module: `col_sweep_ctrl`

## Requirements
- R1: While reset is held and for 64 clocks after it is released, `col_en` selects pixel column k in the k-th clock after release (k = 0..63) and `row_oe` is all ones. All latch enables are low during that time. `col_en` is zero afterwards.
- R2: Each rising edge of `win_clk` uses up one time stamp, and the count starts at 0 after reset. Windows with no hit still use up a stamp.
- R3: At a window edge, every enabled macro-pixel whose `fast_or` is high gets its `latch_en` bit low. No other bit changes, and no bit drops between window edges.
- R4: A window edge that finds no fired macro-pixel pushes nothing and causes no sweep.
- R5: When the scan buffer already holds `DEPTH` maps at a window edge with fired macro-pixels, those macro-pixels stay enabled and `lost_cnt` increments. The next edge that finds space stores the merged map with that edge's stamp.
- R6: Each queued map is announced by a single-cycle `sos` pulse with its stamp on `sos_ts`. Its first column is driven in the next clock, and maps are swept in the order they were queued.
- R7: A sweep drives one pixel column per clock. For macro-pixel column c it sets `col_en` bit 2c, then bit 2c+1. `row_oe` bit r is set when map bit c*NROW+r is set. Columns are visited in ascending order, and columns with no selected row are skipped. Several selected rows in one column are enabled together in one pass. Outside sweeps, `col_en` is zero.
- R8: In the clock after a macro-pixel column's second pixel column, its selected macro-pixels are released: `latch_en` goes high if acquisition is enabled.
- R9: `latch_en` is all zero while both `master_en` and `reg_en` are low, and the two enables are ORed. Maps already queued are still swept to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Asynchronous reset, active high |
| win_clk | input | 1 | Time-window clock; its rising edge ends a window |
| master_en | input | 1 | External acquisition enable |
| reg_en | input | 1 | Register acquisition enable |
| fast_or | input | NCOL*NROW | Per-macro-pixel hit flag |
| latch_en | output | NCOL*NROW | Per-macro-pixel latch enable; low means frozen |
| col_en | output | 2*NCOL | Pixel column enables, two per macro-pixel column |
| row_oe | output | NROW | Row out-enables |
| sos | output | 1 | Start-of-scan strobe |
| sos_ts | output | TS_W | Time stamp of the announced map |
| lost_cnt | output | LOST_W | Count of window edges refused by a full buffer |

## Verification
A rise on `win_clk` passes one sampling register before it is seen. The freeze and push then land on the second clock after the rise. With the sweeper idle, `sos` shows in the same cycle. The first column follows one clock later, and each macro-pixel column then takes two clocks. The release is visible one clock after the second half. The bench drives and samples only on falling edges, and it steps through these cycles one by one. It therefore compares every column and release in the exact cycle the requirements place it. For the overflow case, it fills the buffer behind a long 32-column sweep, so the refused windows fall at known points.

// File: rtl/col_sweep_ctrl.sv
module col_sweep_ctrl #(
  parameter int NCOL   = 32,
  parameter int NROW   = 4,
  parameter int TS_W   = 8,
  parameter int DEPTH  = 8,
  parameter int LOST_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   win_clk,
  input  logic                   master_en,
  input  logic                   reg_en,
  input  logic [NCOL*NROW-1:0]   fast_or,
  output logic [NCOL*NROW-1:0]   latch_en,
  output logic [2*NCOL-1:0]      col_en,
  output logic [NROW-1:0]        row_oe,
  output logic                   sos,
  output logic [TS_W-1:0]        sos_ts,
  output logic [LOST_W-1:0]      lost_cnt
);
  localparam int NMP = NCOL * NROW;
  localparam int NPC = 2 * NCOL;
  localparam int PCW = $clog2(NPC);
  localparam int CW  = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW  = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_CLEAN, S_IDLE, S_SWEEP} state_t;
  state_t st;

  logic [1:0]      win_s;
  logic            win_rise, run, full, push, pop, half;
  logic [NMP-1:0]  frozen, fired, rel, head_map, cur_map;
  logic [TS_W-1:0] tcount;
  logic [NMP-1:0]  fmap [DEPTH];
  logic [TS_W-1:0] fts  [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [NW-1:0]   count;
  logic [NCOL-1:0] colpend, head_cols, cur_bit;
  logic [CW-1:0]   cur;
  logic [PCW-1:0]  clean_pc, sel;

  assign win_rise = win_s[0] & ~win_s[1];
  assign run      = master_en | reg_en;
  assign latch_en = (st == S_CLEAN || !run) ? '0 : ~frozen;
  assign fired    = fast_or & latch_en;
  assign full     = (count == NW'(DEPTH));
  assign push     = win_rise && (|fired) && !full;
  assign pop      = (st == S_IDLE) && (count != '0);
  assign head_map = fmap[rd_ptr];
  assign sos      = pop;
  assign sos_ts   = pop ? fts[rd_ptr] : '0;

  always_comb begin
    for (int c = 0; c < NCOL; c++) head_cols[c] = |head_map[c*NROW +: NROW];
  end

  always_comb begin
    cur = '0;
    for (int c = NCOL - 1; c >= 0; c--) if (colpend[c]) cur = CW'(c);
  end

  assign cur_bit = {{(NCOL-1){1'b0}}, 1'b1} << cur;
  assign sel     = (st == S_CLEAN) ? clean_pc : PCW'({cur, half});
  assign col_en  = (st == S_IDLE) ? '0 : ({{(NPC-1){1'b0}}, 1'b1} << sel);
  assign row_oe  = (st == S_CLEAN) ? '1 :
                   (st == S_SWEEP) ? cur_map[cur*NROW +: NROW] : '0;

  always_comb begin
    rel = '0;
    if (st == S_SWEEP && half) rel[cur*NROW +: NROW] = cur_map[cur*NROW +: NROW];
  end

  always_ff @(posedge clk) begin
    if (push) begin
      fmap[wr_ptr] <= fired;
      fts[wr_ptr]  <= tcount;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      win_s    <= '0;
      tcount   <= '0;
      lost_cnt <= '0;
      frozen   <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      st       <= S_CLEAN;
      clean_pc <= '0;
      colpend  <= '0;
      half     <= 1'b0;
      cur_map  <= '0;
    end else begin
      win_s <= {win_s[0], win_clk};
      if (win_rise) tcount <= tcount + 1'b1;
      if (win_rise && (|fired) && full) lost_cnt <= lost_cnt + 1'b1;
      frozen <= (frozen | (push ? fired : '0)) & ~rel;
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + NW'(push) - NW'(pop);
      case (st)
        S_CLEAN: begin
          clean_pc <= clean_pc + 1'b1;
          if (clean_pc == PCW'(NPC - 1)) st <= S_IDLE;
        end
        S_IDLE: if (pop) begin
          cur_map <= head_map;
          colpend <= head_cols;
          half    <= 1'b0;
          st      <= S_SWEEP;
        end
        default: begin
          half <= ~half;
          if (half) begin
            colpend <= colpend & ~cur_bit;
            if ((colpend & ~cur_bit) == '0) st <= S_IDLE;
          end
        end
      endcase
    end
  end

  a_r7_one_column: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_en));

  a_r7_rows_with_column: assert property (@(posedge clk) disable iff (rst)
    (col_en != '0) |-> (row_oe != '0));

  a_r6_sos_then_column: assert property (@(posedge clk) disable iff (rst)
    sos |=> (col_en != '0));

  a_r5_lost_only_when_full: assert property (@(posedge clk) disable iff (rst)
    (lost_cnt != $past(lost_cnt)) |-> ($past(count) == NW'(DEPTH)));

  a_r4_push_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (count > $past(count)) |-> $past(win_rise));

  a_r3_freeze_only_at_edge: assert property (@(posedge clk) disable iff (rst)
    (!$past(win_rise) && $past(run) && run && $past(st) != S_CLEAN)
      |-> ((~latch_en & $past(latch_en)) == '0));
endmodule

// File: tb/tb_col_sweep_ctrl.sv
module tb_col_sweep_ctrl;
  localparam int NCOL = 32, NROW = 4, NMP = 128, NPC = 64;

  logic clk = 0, rst = 1, win_clk = 0, master_en = 1, reg_en = 0;
  logic [NMP-1:0] fast_or = '0;
  logic [NMP-1:0] latch_en;
  logic [NPC-1:0] col_en;
  logic [NROW-1:0] row_oe;
  logic sos;
  logic [7:0] sos_ts;
  logic [15:0] lost_cnt;

  int n_chk = 0, n_fail = 0, nwin = 0;
  bit done = 0;

  col_sweep_ctrl dut (.clk(clk), .rst(rst), .win_clk(win_clk), .master_en(master_en),
    .reg_en(reg_en), .fast_or(fast_or), .latch_en(latch_en), .col_en(col_en),
    .row_oe(row_oe), .sos(sos), .sos_ts(sos_ts), .lost_cnt(lost_cnt));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic win_edge();
    @(negedge clk); win_clk = 1;
    @(negedge clk);
    @(negedge clk); win_clk = 0;
    nwin++;
  endtask

  task automatic wait_sos();
    int k = 0;
    while (!sos && k < 400) begin @(negedge clk); k++; end
    chk(sos, "R6 sos expected", sos, 1);
  endtask

  task automatic expect_scan(input logic [7:0] ts, input logic [NMP-1:0] map, input bit on);
    chk(sos === 1'b1 && sos_ts === ts, "R6/R2 sos stamp", {sos, sos_ts}, {1'b1, ts});
    for (int c = 0; c < NCOL; c++) if (|map[c*NROW +: NROW]) begin
      @(negedge clk);
      chk(col_en == (64'b1 << (2*c)) && row_oe == map[c*NROW +: NROW], "R7 first half",
          {col_en, row_oe}, {64'b1 << (2*c), map[c*NROW +: NROW]});
      @(negedge clk);
      chk(col_en == (64'b1 << (2*c+1)), "R7 second half", col_en, 64'b1 << (2*c+1));
    end
    @(negedge clk);
    chk(col_en == '0, "R7 idle after sweep", col_en, 0);
    chk((latch_en & map) == (on ? map : '0), "R8 release", latch_en & map, on ? map : '0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(latch_en == '0 && lost_cnt == 0 && sos == 0, "R1 reset state", {latch_en, lost_cnt}, 0);
    rst = 0;
    chk(col_en == 64'b1 && row_oe == 4'hf, "R1 clean column 0", {col_en, row_oe}, {64'b1, 4'hf});
    for (int k = 1; k < NPC; k++) begin
      @(negedge clk);
      chk(col_en == (64'b1 << k) && latch_en == '0, "R1 clean column", col_en, 64'b1 << k);
    end
    @(negedge clk);
    chk(col_en == '0 && latch_en == '1, "R1 clean done", {col_en, latch_en}, {64'b0, {NMP{1'b1}}});
  endtask

  task automatic t_single();
    logic [NMP-1:0] m = '0;
    m[22] = 1;
    fast_or = m;
    win_edge();
    chk(latch_en == ~m, "R3 freeze only the fired one", latch_en, ~m);
    fast_or = '0;
    expect_scan(8'(nwin - 1), m, 1);
  endtask

  task automatic t_empty();
    bit quiet = 1;
    win_edge();
    repeat (10) begin
      @(negedge clk);
      if (sos || col_en != '0) quiet = 0;
    end
    chk(quiet, "R4 empty window gives no sweep", {sos, col_en}, 0);
  endtask

  task automatic t_multi();
    logic [NMP-1:0] m = '0;
    m[4] = 1; m[7] = 1; m[121] = 1;
    fast_or = m;
    win_edge();
    fast_or = '0;
    chk(sos_ts == 8'(2), "R2 empty window used a stamp", sos_ts, 2);
    expect_scan(8'(nwin - 1), m, 1);
  endtask

  task automatic t_enable();
    logic [NMP-1:0] m = '0;
    logic [15:0] lost0 = lost_cnt;
    bit quiet = 1;
    master_en = 0;
    @(negedge clk);
    chk(latch_en == '0, "R9 both enables low", latch_en, 0);
    fast_or[0] = 1;
    win_edge();
    repeat (5) begin
      @(negedge clk);
      if (sos || col_en != '0) quiet = 0;
    end
    chk(quiet && lost_cnt == lost0, "R9 disabled window ignored", {sos, lost_cnt}, {1'b0, lost0});
    fast_or = '0;
    reg_en = 1;
    @(negedge clk);
    chk(latch_en == '1, "R9 register enable alone", latch_en, {NMP{1'b1}});
    m[50] = 1;
    fast_or = m;
    win_edge();
    fast_or = '0;
    reg_en = 0;
    expect_scan(8'(nwin - 1), m, 0);
    master_en = 1;
    @(negedge clk);
    chk(latch_en[50] == 1'b1, "R8 released after queued scan", latch_en[50], 1);
  endtask

  task automatic t_overflow();
    int t0 = nwin;
    logic [NMP-1:0] m0 = '0, mm = '0;
    for (int c = 0; c < NCOL; c++) m0[c*NROW] = 1;
    fast_or = m0;
    win_edge();
    chk(sos && sos_ts == 8'(t0), "R6 long map announced", {sos, sos_ts}, {1'b1, 8'(t0)});
    fast_or = '0;
    for (int k = 1; k <= 8; k++) begin
      fast_or = '0; fast_or[k*NROW+1] = 1;
      win_edge();
    end
    fast_or = '0;
    chk(lost_cnt == 0, "R5 buffer just full", lost_cnt, 0);
    fast_or[82] = 1;
    win_edge();
    chk(lost_cnt == 1 && latch_en[82], "R5 refused window", {lost_cnt, latch_en[82]}, {16'd1, 1'b1});
    fast_or[103] = 1;
    win_edge();
    chk(lost_cnt == 2 && latch_en[82] && latch_en[103], "R5 second refusal",
        {lost_cnt, latch_en[82], latch_en[103]}, {16'd2, 2'b11});
    for (int k = 1; k <= 8; k++) begin
      logic [NMP-1:0] mk = '0;
      mk[k*NROW+1] = 1;
      wait_sos();
      expect_scan(8'(t0 + k), mk, 1);
    end
    mm[82] = 1; mm[103] = 1;
    win_edge();
    fast_or = '0;
    chk(lost_cnt == 2, "R5 merged map stored", lost_cnt, 2);
    expect_scan(8'(t0 + 11), mm, 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_empty();
    t_multi();
    t_enable();
    t_overflow();
    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule